// File: doc/BRIEF.md
# Interface Timer and Interrupt Unit

This block holds the timing and interrupt core of a classic parallel-interface peripheral. It has two 16-bit down-counters, an interrupt flag register with a matching enable register, an auxiliary control byte, a peripheral control byte and a shift-register storage byte. A processor reaches all of them through a 16-entry register window. The window has a 4-bit index, an 8-bit write bus, a combinational read bus and separate read and write strobes. Both counters advance only on cycles when the `tick` enable is high. Rising edges on five external event inputs latch into the low flag bits.

The flags follow the usual conventions for this kind of peripheral. Some register reads and writes clear a flag as a side effect. The enable register is written with a set-or-clear selector in bit 7. Bit 7 of the flag read-back is a summary of all enabled, pending flags. The `irq` output is high while any enabled flag is pending.

Flag bit positions: bit 0..4 = event inputs `evt_in[0..4]`, bit 2 also cleared by a shift-register read, bit 5 = counter B, bit 6 = counter A.

Top module: `vit_irq_unit`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears the flags, the enables, the auxiliary byte (index 11), the peripheral byte (index 12), the shift byte (index 10) and the counter-A latch. Afterwards index 13 reads 0x00, index 14 reads 0x80 and `irq` is low.
- R2: Reset leaves both counters unchanged. A counter value loaded before reset reads back unchanged after it.
- R3: Counter A decrements on each tick. A tick taken at count 0 sets flag bit 6. It then reloads from the latch when auxiliary bit 6 is 1, and otherwise wraps to 0xFFFF.
- R4: Writes to index 4 and 6 set the counter-A latch low byte, and a write to index 7 sets only its high byte. A write to index 5 sets the latch high byte, copies the whole latch into counter A and clears flag bit 6.
- R5: Counter B holds while auxiliary bit 5 is 1. Index 8 stores its low latch byte. A write to index 9 loads the counter from {data, low latch}, clears flag bit 5 and arms it. Flag bit 5 is set only by the first underflow after arming.
- R6: Reads of index 4, 8 and 10 clear flag bits 6, 5 and 2 respectively. These are the only reads with a side effect.
- R7: Index 13 reads the flags in bits 6..0, with bit 7 = 1 exactly when some flag is set together with its enable.
- R8: A write to index 13 clears every flag whose bit is 1 in the data.
- R9: A write to index 14 with bit 7 = 1 sets the enables named in bits 6..0, and with bit 7 = 0 clears them. Index 14 reads the enables with bit 7 = 1.
- R10: A rising edge on `evt_in[k]` sets flag bit k. An input held high does not set the flag again.
- R11: When a hardware set and an access-driven clear hit the same flag in one cycle, the flag ends set.
- R12: `irq` is high exactly when some enabled flag is pending. It changes in the cycle after the register access that changes a flag or an enable.
- R13: Read-back map: 5 = counter A high, 6/7 = latch A low/high, 8/9 = counter B low/high, 10 = shift byte, 11 = auxiliary byte, 12 = peripheral byte. Indices 0..3 and 15 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| reg_idx | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at the clock edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `reg_idx` |
| evt_in | input | 5 | External event inputs, rising-edge sensitive |
| irq | output | 1 | Active-high interrupt request |

## Verification
The block has no parameters, so the bench builds it exactly as delivered. Small latch values put counter underflow, free-run reload and one-shot wrap within a few ticks of each load. One run of a little over 65,536 ticks confirms that counter B does not raise its flag again without being re-armed. Directed steps line up an event edge with a flag-clearing write in the same cycle, and reload a counter just before reset, to reach the priority and reset-retention corners.

// File: rtl/vit_irq_unit.sv
module vit_irq_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] reg_idx,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [4:0] evt_in,
  output logic       irq
);

  localparam logic [3:0] IX_A_LO  = 4'd4;
  localparam logic [3:0] IX_A_HI  = 4'd5;
  localparam logic [3:0] IX_AL_LO = 4'd6;
  localparam logic [3:0] IX_AL_HI = 4'd7;
  localparam logic [3:0] IX_B_LO  = 4'd8;
  localparam logic [3:0] IX_B_HI  = 4'd9;
  localparam logic [3:0] IX_SHIFT = 4'd10;
  localparam logic [3:0] IX_AUX   = 4'd11;
  localparam logic [3:0] IX_PERI  = 4'd12;
  localparam logic [3:0] IX_FLAG  = 4'd13;
  localparam logic [3:0] IX_ENAB  = 4'd14;

  logic [15:0] cnt_a, lat_a, cnt_b;
  logic [7:0]  lat_b_lo, aux, peri, shf;
  logic [6:0]  flg, ena, clr, set;
  logic [4:0]  evt_q, evt_rise;
  logic        b_armed, a_uf, b_fire;

  wire wa = wr_en && reg_idx == IX_A_HI;
  wire wb = wr_en && reg_idx == IX_B_HI;

  assign evt_rise = evt_in & ~evt_q;
  assign a_uf     = tick && cnt_a == 16'h0 && !wa;
  assign b_fire   = tick && !aux[5] && cnt_b == 16'h0 && b_armed && !wb;
  assign irq      = |(flg & ena);

  always_comb begin
    clr = '0;
    if (wr_en) begin
      if (reg_idx == IX_A_HI) clr[6] = 1'b1;
      if (reg_idx == IX_B_HI) clr[5] = 1'b1;
      if (reg_idx == IX_FLAG) clr = clr | wdata[6:0];
    end
    if (rd_en) begin
      if (reg_idx == IX_A_LO)  clr[6] = 1'b1;
      if (reg_idx == IX_B_LO)  clr[5] = 1'b1;
      if (reg_idx == IX_SHIFT) clr[2] = 1'b1;
    end
  end

  assign set = {a_uf, b_fire, evt_rise};

  always_comb begin
    case (reg_idx)
      IX_A_LO:  rdata = cnt_a[7:0];
      IX_A_HI:  rdata = cnt_a[15:8];
      IX_AL_LO: rdata = lat_a[7:0];
      IX_AL_HI: rdata = lat_a[15:8];
      IX_B_LO:  rdata = cnt_b[7:0];
      IX_B_HI:  rdata = cnt_b[15:8];
      IX_SHIFT: rdata = shf;
      IX_AUX:   rdata = aux;
      IX_PERI:  rdata = peri;
      IX_FLAG:  rdata = {irq, flg};
      IX_ENAB:  rdata = {1'b1, ena};
      default:  rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wa)
      cnt_a <= {wdata, lat_a[7:0]};
    else if (tick)
      cnt_a <= (cnt_a == 16'h0 && aux[6]) ? lat_a : cnt_a - 16'h1;
    if (wb)
      cnt_b <= {wdata, lat_b_lo};
    else if (tick && !aux[5])
      cnt_b <= cnt_b - 16'h1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a    <= '0;
      lat_b_lo <= '0;
      aux      <= '0;
      peri     <= '0;
      shf      <= '0;
      flg      <= '0;
      ena      <= '0;
      evt_q    <= '0;
      b_armed  <= 1'b0;
    end else begin
      evt_q <= evt_in;
      flg   <= (flg & ~clr) | set;
      if (wb) b_armed <= 1'b1;
      else if (b_fire) b_armed <= 1'b0;
      if (wr_en) begin
        case (reg_idx)
          IX_A_LO, IX_AL_LO: lat_a[7:0] <= wdata;
          IX_A_HI, IX_AL_HI: lat_a[15:8] <= wdata;
          IX_B_LO:  lat_b_lo <= wdata;
          IX_SHIFT: shf <= wdata;
          IX_AUX:   aux <= wdata;
          IX_PERI:  peri <= wdata;
          IX_ENAB:  ena <= wdata[7] ? (ena | wdata[6:0]) : (ena & ~wdata[6:0]);
          default:  ;
        endcase
      end
    end
  end

  a_r4_load_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    wa |=> cnt_a == {$past(wdata), $past(lat_a[7:0])});

  a_r3_free_run_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_a == 16'h0 && aux[6] && !wa) |=> cnt_a == $past(lat_a) && flg[6]);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_FLAG && !tick && evt_rise == 5'b0) |=> (flg & $past(wdata[6:0])) == 7'h0);

  a_r9_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_ENAB && wdata[7]) |=> (ena & $past(wdata[6:0])) == $past(wdata[6:0]));

  a_r9_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_ENAB && !wdata[7]) |=> (ena & $past(wdata[6:0])) == 7'h0);

  a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in[1] && !evt_q[1]) |=> flg[1]);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (aux[5] && !wb) |=> $stable(cnt_b));

  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ena == 7'h0) |-> !irq);

endmodule

// File: tb/test_vit_irq_unit.sv
module test_vit_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] reg_idx = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] evt_in = '0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vit_irq_unit i_vit_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_idx(reg_idx),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .evt_in(evt_in), .irq(irq)
  );

  // fields: rd, idx, data, expected, ticks after, requirement number
  localparam int NV = 31;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd11, 8'h60, 8'h00, 4'd0, 4'd13}, // R13 aux: free run, B held
    {1'b1, 4'd11, 8'h00, 8'h60, 4'd0, 4'd13}, // R13
    {1'b0, 4'd4,  8'h05, 8'h00, 4'd0, 4'd4},  // R4
    {1'b0, 4'd5,  8'h00, 8'h00, 4'd0, 4'd4},  // R4 transfer
    {1'b1, 4'd6,  8'h00, 8'h05, 4'd0, 4'd13}, // R13
    {1'b1, 4'd7,  8'h00, 8'h00, 4'd0, 4'd13}, // R13
    {1'b1, 4'd5,  8'h00, 8'h00, 4'd0, 4'd13}, // R13
    {1'b1, 4'd4,  8'h00, 8'h05, 4'd6, 4'd3},  // R3 then underflow
    {1'b1, 4'd13, 8'h00, 8'h40, 4'd0, 4'd7},  // R7
    {1'b0, 4'd14, 8'hC0, 8'h00, 4'd0, 4'd9},  // R9
    {1'b1, 4'd14, 8'h00, 8'hC0, 4'd0, 4'd9},  // R9
    {1'b1, 4'd13, 8'h00, 8'hC0, 4'd0, 4'd7},  // R7 summary bit
    {1'b1, 4'd4,  8'h00, 8'h05, 4'd0, 4'd3},  // R3 reloaded
    {1'b1, 4'd13, 8'h00, 8'h00, 4'd0, 4'd6},  // R6 cleared by read
    {1'b0, 4'd7,  8'h12, 8'h00, 4'd0, 4'd4},  // R4 latch high only
    {1'b1, 4'd5,  8'h00, 8'h00, 4'd0, 4'd4},  // R4 no transfer
    {1'b1, 4'd7,  8'h00, 8'h12, 4'd0, 4'd4},  // R4
    {1'b0, 4'd14, 8'h40, 8'h00, 4'd0, 4'd9},  // R9 clear
    {1'b1, 4'd14, 8'h00, 8'h80, 4'd0, 4'd9},  // R9
    {1'b0, 4'd10, 8'hA5, 8'h00, 4'd0, 4'd13}, // R13
    {1'b1, 4'd10, 8'h00, 8'hA5, 4'd0, 4'd6},  // R6
    {1'b0, 4'd8,  8'h02, 8'h00, 4'd0, 4'd5},  // R5
    {1'b0, 4'd11, 8'h00, 8'h00, 4'd0, 4'd5},  // R5 B runs, A one-shot
    {1'b0, 4'd9,  8'h00, 8'h00, 4'd3, 4'd5},  // R5 load 2, fire on 3rd
    {1'b1, 4'd13, 8'h00, 8'h20, 4'd0, 4'd5},  // R5
    {1'b1, 4'd8,  8'h00, 8'hFF, 4'd4, 4'd5},  // R5 wrapped, clears
    {1'b1, 4'd13, 8'h00, 8'h40, 4'd0, 4'd3},  // R3 A wrapped
    {1'b1, 4'd4,  8'h00, 8'hFE, 4'd0, 4'd3},  // R3
    {1'b1, 4'd5,  8'h00, 8'hFF, 4'd0, 4'd3},  // R3
    {1'b0, 4'd13, 8'h7F, 8'h00, 4'd0, 4'd8},  // R8
    {1'b1, 4'd13, 8'h00, 8'h00, 4'd0, 4'd8}   // R8
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ix, input logic [7:0] d);
    @(negedge clk);
    reg_idx = ix; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ix, input logic [7:0] msk, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_idx = ix; rd_en = 1'b1;
    #1 chk(rdata & msk, exp, req);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1;
    end
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk);
    chk({7'h0, irq}, {7'h0, exp}, req);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(4'd13, 8'hFF, 8'h00, "R1");
    rd(4'd14, 8'hFF, 8'h80, "R1");
    rd(4'd11, 8'hFF, 8'h00, "R1");
    rd(4'd10, 8'hFF, 8'h00, "R1");
    rd(4'd6,  8'hFF, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      if (e[28]) rd(e[27:24], 8'hFF, e[15:8], $sformatf("R%0d row %0d", e[3:0], v));
      else wr(e[27:24], e[23:16]);
      ticks(int'(e[7:4]));
    end

    // R10 event edge, R12 irq follow
    @(negedge clk); evt_in = 5'b00010;
    @(negedge clk); evt_in = 5'b00000;
    rd(4'd13, 8'hFF, 8'h02, "R10");
    chk_irq(1'b0, "R12");
    wr(4'd14, 8'h82);
    chk_irq(1'b1, "R12");
    rd(4'd13, 8'hFF, 8'h82, "R7");
    wr(4'd13, 8'h02);
    chk_irq(1'b0, "R12");
    wr(4'd14, 8'h02);

    // R11 set beats clear
    @(negedge clk); evt_in = 5'b00001;
    @(negedge clk); evt_in = 5'b00000;
    @(negedge clk);
    evt_in = 5'b00001; reg_idx = 4'd13; wdata = 8'h01; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    rd(4'd13, 8'hFF, 8'h01, "R11");
    // R10 level held: no re-set after clear
    wr(4'd13, 8'h01);
    rd(4'd13, 8'hFF, 8'h00, "R10");
    @(negedge clk); evt_in = 5'b00000;

    // R5 hold, load, single fire
    wr(4'd11, 8'h20);
    wr(4'd8, 8'h03);
    wr(4'd9, 8'h00);
    ticks(5);
    rd(4'd8, 8'hFF, 8'h03, "R5");
    rd(4'd9, 8'hFF, 8'h00, "R13");
    wr(4'd11, 8'h00);
    ticks(3);
    rd(4'd13, 8'h20, 8'h00, "R5");
    ticks(1);
    rd(4'd13, 8'h20, 8'h20, "R5");
    wr(4'd13, 8'h20);
    ticks(65540);
    rd(4'd13, 8'h20, 8'h00, "R5");

    // R2 counters survive reset, R1 registers cleared
    wr(4'd4, 8'h34);
    wr(4'd5, 8'h12);
    wr(4'd11, 8'h55);
    wr(4'd12, 8'hAA);
    rd(4'd12, 8'hFF, 8'hAA, "R13");
    wr(4'd14, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd5,  8'hFF, 8'h12, "R2");
    rd(4'd4,  8'hFF, 8'h34, "R2");
    rd(4'd7,  8'hFF, 8'h00, "R1");
    rd(4'd11, 8'hFF, 8'h00, "R1");
    rd(4'd12, 8'hFF, 8'h00, "R1");
    rd(4'd14, 8'hFF, 8'h80, "R1");
    chk_irq(1'b0, "R1");

    // R13 unmapped indices
    wr(4'd2, 8'hFF);
    rd(4'd2,  8'hFF, 8'h00, "R13");
    rd(4'd15, 8'hFF, 8'h00, "R13");

    finish_run();
  end
endmodule